// File: doc/BRIEF.md
# DRAM Refresh Request Arbiter

This block decides when a shared DRAM gets refreshed. The host CPU and a second processor share the DRAM. The block counts host clock cycles from the last refresh. Once the count is complete it waits for the host to begin fetching an instruction. It then holds the host off by dropping its ready line and raises a refresh enable. When the second processor owns the bus, the host-side stall is suppressed. The refresh need is passed to the second processor as an active-low request, and the refresh enable follows that processor's active-low grant.

Each refresh enable does three things:
- It restarts the cycle count.
- It advances an 8-bit row counter used for refresh.
- It steers the DRAM address multiplexer to that row counter.

When no refresh is running, the multiplexer passes either the second processor's address or one half of the host address, as picked by a row/column phase input. Generating DRAM strobes and timing is left to neighbouring logic.

Top module: `dram_refresh_arbiter`

## Requirements
- R1: After reset, or after a cycle in which refresh_en was high, the cycle count restarts from zero. The terminal condition is reached after exactly CYCLE_LIMIT (default 24) clocks, and it then holds until the next refresh_en.
- R2: ext_req_n is low in exactly those cycles in which the terminal condition holds and sync is high. It is not registered.
- R3: If ext_req_n is low and ext_own is low in a cycle, rdy is low in the following cycle. rdy is driven from a register.
- R4: refresh_en is high whenever ext_grant_n is low, or the request was registered on the previous edge.
- R5: A refresh restarts the count. With sync held high, exactly CYCLE_LIMIT cycles with refresh_en low and ext_req_n high pass before the next request.
- R6: While ext_own is high, the request is not registered. rdy is therefore high in every cycle that follows a cycle with ext_own high.
- R7: ref_addr advances by one on every low-to-high transition of refresh_en, and wraps modulo 256.
- R8: While refresh_en is high, dram_addr equals ref_addr.
- R9: While refresh_en is low and ext_own is high, dram_addr equals ext_addr.
- R10: While refresh_en and ext_own are both low, dram_addr is host_addr[7:0] when col_sel is 0 and host_addr[15:8] when col_sel is 1.
- R11: During synchronous reset, and on the first cycle after it, rdy is 1, ref_addr is 0 and ext_req_n is 1. refresh_en is 0 unless ext_grant_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| sync | input | 1 | High while the host fetches an opcode |
| ext_own | input | 1 | High while the second processor owns the DRAM bus |
| ext_grant_n | input | 1 | Active-low refresh grant from the second processor |
| col_sel | input | 1 | Host address phase: 0 selects bits 7..0, 1 selects bits 15..8 |
| host_addr | input | 16 | Host CPU address |
| ext_addr | input | 8 | Multiplexed address from the second processor |
| rdy | output | 1 | Host ready; low stalls the host |
| refresh_en | output | 1 | Refresh in progress |
| ext_req_n | output | 1 | Active-low refresh request to the second processor |
| ref_addr | output | 8 | Refresh row counter |
| dram_addr | output | 8 | Address presented to the DRAM |

## Verification
Holding sync high shows the exact count length. It also shows the gap between refreshes, because every cycle after the terminal count is an instruction boundary.

Holding ext_own high with no grant shows two things apart: a request that is waiting for the second processor, and a host stall that must not happen. A long train of grant pulses walks the row counter through its wrap.

Random sync, ownership, grant and phase patterns mix the three sources of the address multiplexer with refresh cycles. They separate priority errors from phase errors.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    SRC_HOST_LO = 2'd0,
    SRC_HOST_HI = 2'd1,
    SRC_EXT     = 2'd2,
    SRC_REF     = 2'd3
  } addr_src_e;

  function automatic addr_src_e pick_src(input logic ref_on,
                                         input logic ext_on,
                                         input logic hi_half);
    if (ref_on)       return SRC_REF;
    else if (ext_on)  return SRC_EXT;
    else if (hi_half) return SRC_HOST_HI;
    else              return SRC_HOST_LO;
  endfunction

endpackage

// File: rtl/ref_cycle_timer.sv
module ref_cycle_timer #(
  parameter int CYCLE_LIMIT = 24,
  parameter int CW          = $clog2(CYCLE_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic tc
);
  localparam logic [CW-1:0] LIMIT_V = CW'(CYCLE_LIMIT);

  logic [CW-1:0] cnt;

  assign tc = (cnt == LIMIT_V);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (!tc) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ref_req_stage.sv
module ref_req_stage (
  input  logic clk,
  input  logic rst,
  input  logic tc,
  input  logic sync,
  input  logic ext_own,
  input  logic ext_grant_n,
  output logic req_raw,
  output logic refresh_en,
  output logic rdy
);
  logic req_q;

  assign req_raw    = tc & sync;
  assign refresh_en = req_q | ~ext_grant_n;
  assign rdy        = ~req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_raw & ~ext_own;
    end
  end
endmodule

// File: rtl/ref_row_counter.sv
module ref_row_counter #(
  parameter int RA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  output logic [RA_W-1:0] row
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      row  <= '0;
    end else begin
      en_q <= en;
      if (en && !en_q) begin
        row <= row + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ref_addr_mux.sv
module ref_addr_mux
  import dram_ref_pkg::*;
#(
  parameter int RA_W = 8,
  parameter int HA_W = 2 * RA_W
) (
  input  logic            ref_on,
  input  logic            ext_on,
  input  logic            hi_half,
  input  logic [RA_W-1:0] ref_row,
  input  logic [RA_W-1:0] ext_addr,
  input  logic [HA_W-1:0] host_addr,
  output logic [RA_W-1:0] dram_addr
);
  addr_src_e src;

  always_comb begin
    src = pick_src(ref_on, ext_on, hi_half);
    unique case (src)
      SRC_REF:     dram_addr = ref_row;
      SRC_EXT:     dram_addr = ext_addr;
      SRC_HOST_HI: dram_addr = host_addr[HA_W-1:RA_W];
      default:     dram_addr = host_addr[RA_W-1:0];
    endcase
  end
endmodule

// File: rtl/dram_refresh_arbiter.sv
module dram_refresh_arbiter #(
  parameter int CYCLE_LIMIT = 24,
  parameter int RA_W        = 8,
  parameter int HA_W        = 2 * RA_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sync,
  input  logic            ext_own,
  input  logic            ext_grant_n,
  input  logic            col_sel,
  input  logic [HA_W-1:0] host_addr,
  input  logic [RA_W-1:0] ext_addr,
  output logic            rdy,
  output logic            refresh_en,
  output logic            ext_req_n,
  output logic [RA_W-1:0] ref_addr,
  output logic [RA_W-1:0] dram_addr
);
  localparam int CNT_W = $clog2(CYCLE_LIMIT + 1);

  logic tc;
  logic req_raw;

  ref_cycle_timer #(.CYCLE_LIMIT(CYCLE_LIMIT), .CW(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (refresh_en),
    .tc    (tc)
  );

  ref_req_stage u_req (
    .clk         (clk),
    .rst         (rst),
    .tc          (tc),
    .sync        (sync),
    .ext_own     (ext_own),
    .ext_grant_n (ext_grant_n),
    .req_raw     (req_raw),
    .refresh_en  (refresh_en),
    .rdy         (rdy)
  );

  assign ext_req_n = ~req_raw;

  ref_row_counter #(.RA_W(RA_W)) u_row (
    .clk (clk),
    .rst (rst),
    .en  (refresh_en),
    .row (ref_addr)
  );

  ref_addr_mux #(.RA_W(RA_W), .HA_W(HA_W)) u_mux (
    .ref_on    (refresh_en),
    .ext_on    (ext_own),
    .hi_half   (col_sel),
    .ref_row   (ref_addr),
    .ext_addr  (ext_addr),
    .host_addr (host_addr),
    .dram_addr (dram_addr)
  );
endmodule

// File: rtl/ref_arb_checker.sv
module ref_arb_checker #(
  parameter int RA_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            sync,
  input logic            ext_own,
  input logic            ext_grant_n,
  input logic            rdy,
  input logic            refresh_en,
  input logic            ext_req_n,
  input logic [RA_W-1:0] ref_addr,
  input logic [RA_W-1:0] ext_addr,
  input logic [RA_W-1:0] dram_addr
);
  p_req_needs_sync_r2: assert property (@(posedge clk) disable iff (rst)
    !ext_req_n |-> sync);

  p_stall_after_req_r3: assert property (@(posedge clk) disable iff (rst)
    (!ext_req_n && !ext_own) |=> !rdy);

  p_grant_enables_r4: assert property (@(posedge clk) disable iff (rst)
    !ext_grant_n |-> refresh_en);

  p_own_keeps_rdy_r6: assert property (@(posedge clk) disable iff (rst)
    ext_own |=> rdy);

  p_row_step_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(refresh_en) |=> (ref_addr == $past(ref_addr) + 1'b1));

  p_row_steady_r7: assert property (@(posedge clk) disable iff (rst)
    !refresh_en |=> $stable(ref_addr));

  p_refresh_prio_r8: assert property (@(posedge clk) disable iff (rst)
    refresh_en |-> (dram_addr == ref_addr));

  p_ext_select_r9: assert property (@(posedge clk) disable iff (rst)
    (!refresh_en && ext_own) |-> (dram_addr == ext_addr));
endmodule

bind dram_refresh_arbiter ref_arb_checker #(.RA_W(RA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sync        (sync),
  .ext_own     (ext_own),
  .ext_grant_n (ext_grant_n),
  .rdy         (rdy),
  .refresh_en  (refresh_en),
  .ext_req_n   (ext_req_n),
  .ref_addr    (ref_addr),
  .ext_addr    (ext_addr),
  .dram_addr   (dram_addr)
);

// File: tb/dram_refresh_arbiter_test.sv
module dram_refresh_arbiter_test;
  localparam int LIMIT = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync = 1'b0;
  logic        ext_own = 1'b0;
  logic        ext_grant_n = 1'b1;
  logic        col_sel = 1'b0;
  logic [15:0] host_addr = '0;
  logic [7:0]  ext_addr = '0;
  logic        rdy, refresh_en, ext_req_n;
  logic [7:0]  ref_addr, dram_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int       m_cnt;
  bit       m_req_q, m_en_q;
  bit [7:0] m_ref;

  bit       s_rdy, s_en, s_req_n;
  bit [7:0] s_ref, s_dram;

  dram_refresh_arbiter uut (
    .clk(clk), .rst(rst), .sync(sync), .ext_own(ext_own),
    .ext_grant_n(ext_grant_n), .col_sel(col_sel), .host_addr(host_addr),
    .ext_addr(ext_addr), .rdy(rdy), .refresh_en(refresh_en),
    .ext_req_n(ext_req_n), .ref_addr(ref_addr), .dram_addr(dram_addr)
  );

  always #4 clk = ~clk;

  function automatic bit f_tc(int c);
    return c == LIMIT;
  endfunction

  function automatic bit f_en(bit rq, bit gn);
    return rq | ~gn;
  endfunction

  function automatic bit [7:0] f_dram(bit en, bit own, bit cs, bit [15:0] ha,
                                      bit [7:0] ea, bit [7:0] ra);
    if (en) return ra;
    if (own) return ea;
    return cs ? ha[15:8] : ha[7:0];
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    bit e_req, e_en;
    string mtag;
    #1;
    e_req = f_tc(m_cnt) & sync;
    e_en  = f_en(m_req_q, ext_grant_n);
    if (!rst) begin
      chk("R2 ext_req_n", ext_req_n, !e_req);
      chk("R3 rdy", rdy, !m_req_q);
      chk("R4 refresh_en", refresh_en, e_en);
      chk("R7 ref_addr", ref_addr, m_ref);
      mtag = e_en ? "R8 dram_addr" : (ext_own ? "R9 dram_addr" : "R10 dram_addr");
      chk(mtag, dram_addr,
          f_dram(e_en, ext_own, col_sel, host_addr, ext_addr, m_ref));
    end
    s_rdy = rdy; s_en = refresh_en; s_req_n = ext_req_n;
    s_ref = ref_addr; s_dram = dram_addr;
    @(posedge clk);
    if (rst) begin
      m_cnt = 0; m_req_q = 0; m_en_q = 0; m_ref = '0;
    end else begin
      if (e_en && !m_en_q) m_ref = m_ref + 1'b1;
      m_en_q  = e_en;
      m_req_q = e_req & ~ext_own;
      if (e_en) m_cnt = 0;
      else if (!f_tc(m_cnt)) m_cnt = m_cnt + 1;
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    bit [7:0] start_ref;
    void'($urandom(32'h5eed_1234));
    m_cnt = 0; m_req_q = 0; m_en_q = 0; m_ref = '0;
    @(negedge clk);

    // R11 reset state
    rst = 1'b1; sync = 1'b1;
    step(); step();
    rst = 1'b0;
    step();
    chk("R11 rdy after reset", s_rdy, 1);
    chk("R11 refresh_en after reset", s_en, 0);
    chk("R11 ref_addr after reset", s_ref, 0);
    chk("R11 ext_req_n after reset", s_req_n, 1);

    // R1 count length from reset with sync held high
    n = 1;
    for (int i = 0; i < 60; i++) begin
      step();
      if (!s_req_n) break;
      n++;
    end
    chk("R1 cycles before first request", n, LIMIT);

    // R3 stall and R4 refresh enable the cycle after the request
    step();
    chk("R3 rdy low after request", s_rdy, 0);
    chk("R4 refresh_en from registered request", s_en, 1);

    // R5 gap to next request
    do step(); while (s_en);
    n = 1;
    for (int i = 0; i < 60; i++) begin
      step();
      if (!s_req_n) break;
      n++;
    end
    chk("R5 cycles between refreshes", n, LIMIT);

    // R6 second processor owns the bus: no stall, request waits for grant
    ext_own = 1'b1;
    step();
    for (int i = 0; i < 39; i++) begin
      step();
      chk("R6 rdy high while ext_own", s_rdy, 1);
    end
    chk("R2 request pending until grant", s_req_n, 0);
    ext_grant_n = 1'b0;
    step();
    chk("R4 refresh_en from grant", s_en, 1);
    ext_grant_n = 1'b1;
    step();

    // R7 wrap of the row counter over 256 grant pulses
    sync = 1'b0;
    start_ref = s_ref;
    for (int i = 0; i < 256; i++) begin
      ext_grant_n = 1'b0; step();
      ext_grant_n = 1'b1; step();
    end
    chk("R7 ref_addr wraps after 256 refreshes", s_ref, start_ref);

    // R10 host halves, R9 external select
    ext_own = 1'b0; host_addr = 16'hA55A; ext_addr = 8'h3C;
    col_sel = 1'b0; step();
    chk("R10 low half", s_dram, 8'h5A);
    col_sel = 1'b1; step();
    chk("R10 high half", s_dram, 8'hA5);
    ext_own = 1'b1; step();
    chk("R9 external address", s_dram, 8'h3C);
    ext_grant_n = 1'b0; step();
    chk("R8 refresh priority", s_dram, s_ref);
    ext_grant_n = 1'b1;

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 100 < 3) ext_own = ~ext_own;
      sync        = ($urandom % 4) == 0;
      ext_grant_n = !(ext_own && ($urandom % 6 == 0));
      col_sel     = $urandom % 2;
      host_addr   = 16'($urandom);
      ext_addr    = 8'($urandom);
      rst         = ($urandom % 700) == 0;
      step();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule